// File: doc/BRIEF.md
# Floating-Point Invalid and Divide-by-Zero Screen

This block screens a single-precision floating-point operation before or alongside its arithmetic unit. It takes an operation selector and one or two 32-bit operands and decides whether the operation raises the invalid-operation exception or the divide-by-zero exception. It does not compute the arithmetic result. Each operand is first sorted into one of five classes: zero, finite nonzero (subnormals included), infinity, quiet NaN or signaling NaN. A rule stage then applies the conditions for the selected operation.

When a flag is raised and the destination holds a floating-point value, the block also supplies the result to write when no trap is taken. That result is the canonical quiet NaN for an invalid operation, or an infinity carrying the XOR of the operand signs for a division by zero. The decision is registered, so each accepted request produces its verdict exactly one clock later. A new request may be accepted on every cycle.

Top module: `fp_exc_screen`

## Requirements
- R1: A request presented with `in_valid` high is answered with `out_valid` high on the next clock edge. Cycles without a request leave `out_valid`, `invalid`, `div_zero` and `subst_valid` low. The `op` codes are: 0 add, 1 subtract, 2 multiply, 3 divide, 4 square root, 5 convert to signed 32-bit integer, 6 equality compare, 7 ordered compare.
- R2: Add and subtract are invalid when both operands are infinities and the effective operation subtracts magnitudes. For add this means the signs differ; for subtract it means the signs match. A same-sign sum of infinities is not invalid.
- R3: Multiply is invalid when one operand is zero and the other is infinity, whatever the signs.
- R4: Divide is invalid for zero divided by zero and for infinity divided by infinity, whatever the signs.
- R5: Square root is invalid for a negative nonzero operand, including negative infinity and negative subnormals. Negative zero and a negative quiet NaN are not invalid.
- R6: Convert is invalid when the operand is an infinity or a NaN, or when its magnitude is at least 2^31. The single exception is the value -2^31 (0xCF000000), which fits and is not invalid.
- R7: A signaling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear) in any operand the operation uses makes it invalid. A quiet NaN (fraction bit 22 set) alone does not make arithmetic invalid. Square root and convert ignore `opb` entirely.
- R8: The ordered compare is invalid when either operand is any NaN. The equality compare is invalid only when an operand is a signaling NaN.
- R9: `div_zero` is raised only for divide, only when the divisor `opb` is a zero and the dividend `opa` is finite and nonzero. It is never raised together with `invalid`.
- R10: Invalid add, subtract, multiply, divide or square root give `subst_valid`=1 and `subst`=0x7FC00000. A division by zero gives `subst_valid`=1 and `subst` = {sign(opa) XOR sign(opb), 0x7F800000 in bits 30:0}. Every other verdict gives `subst_valid`=0 and `subst`=0.
- R11: While `rst` is high at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation selector (codes in R1) |
| opa | input | 32 | First operand, or the only operand of unary operations |
| opb | input | 32 | Second operand (divisor for divide) |
| out_valid | output | 1 | Verdict for the request of the previous cycle |
| invalid | output | 1 | Invalid-operation exception |
| div_zero | output | 1 | Divide-by-zero exception |
| subst_valid | output | 1 | `subst` holds the untrapped default result |
| subst | output | 32 | Untrapped default result |

## Verification
The only state in this block is one output register stage, so a fault in it shows up at the ports on the very next cycle. It can appear as a lost or spurious `out_valid`, as a flag paired with the wrong request, or as flags that stay high on an idle cycle. Faults in the classification or rule logic show up as a wrong flag or substitute value for the specific operand pattern that exercises them. For that reason the vectors cover each boundary: signs of zeros and infinities, quiet versus signaling NaN, subnormals, and the conversion limit on either side of 2^31. Each verdict is compared one cycle after its request.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int FP_W  = 1 + EXP_W + MAN_W;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int OP_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_DIV  = 3'd3,
        OP_SQRT = 3'd4,
        OP_CVT  = 3'd5,
        OP_CEQ  = 3'd6,
        OP_CORD = 3'd7
    } fpx_op_e;

    typedef enum logic [2:0] {
        CL_ZERO = 3'd0,
        CL_FIN  = 3'd1,
        CL_INF  = 3'd2,
        CL_QNAN = 3'd3,
        CL_SNAN = 3'd4
    } fpx_cls_e;

    typedef struct packed {
        fpx_cls_e         cls;
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fpx_opnd_t;

    typedef struct packed {
        logic            invalid;
        logic            div_zero;
        logic            subst_valid;
        logic [FP_W-1:0] subst;
    } fpx_verdict_t;

    localparam logic [FP_W-1:0] QNAN_DEF =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    function automatic logic is_nan(fpx_cls_e c);
        return (c == CL_QNAN) || (c == CL_SNAN);
    endfunction

    function automatic logic has_fp_dest(fpx_op_e o);
        return (o == OP_ADD) || (o == OP_SUB) || (o == OP_MUL) ||
               (o == OP_DIV) || (o == OP_SQRT);
    endfunction

    function automatic logic [FP_W-1:0] signed_inf(logic s);
        return {s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
    import fpx_pkg::*;
(
    input  logic [FP_W-1:0] word,
    output fpx_opnd_t       info
);
    logic             s;
    logic [EXP_W-1:0] e;
    logic [MAN_W-1:0] m;

    assign s = word[FP_W-1];
    assign e = word[FP_W-2:MAN_W];
    assign m = word[MAN_W-1:0];

    always_comb begin
        info.sign = s;
        info.exp  = e;
        info.man  = m;
        if (e == {EXP_W{1'b1}}) begin
            if (m == '0)          info.cls = CL_INF;
            else if (m[MAN_W-1])  info.cls = CL_QNAN;
            else                  info.cls = CL_SNAN;
        end else if (e == '0 && m == '0) begin
            info.cls = CL_ZERO;
        end else begin
            info.cls = CL_FIN;
        end
    end
endmodule

// File: rtl/fpx_rules.sv
module fpx_rules
    import fpx_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  fpx_op_e      op,
    input  fpx_opnd_t    a,
    input  fpx_opnd_t    b,
    output fpx_verdict_t verdict
);
    localparam int CVT_LIM_EXP = BIAS + INT_W - 1;

    logic uses_b;
    logic snan_hit;
    logic rule_hit;
    logic cvt_over;
    logic dz;
    logic inv;

    assign uses_b   = !(op == OP_SQRT || op == OP_CVT);
    assign snan_hit = (a.cls == CL_SNAN) || (uses_b && b.cls == CL_SNAN);

    assign cvt_over = (a.cls == CL_FIN) && (int'(a.exp) >= CVT_LIM_EXP) &&
                      !(a.sign && int'(a.exp) == CVT_LIM_EXP && a.man == '0);

    always_comb begin
        rule_hit = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB:
                rule_hit = (a.cls == CL_INF) && (b.cls == CL_INF) &&
                           (a.sign ^ b.sign ^ (op == OP_SUB));
            OP_MUL:
                rule_hit = (a.cls == CL_ZERO && b.cls == CL_INF) ||
                           (a.cls == CL_INF  && b.cls == CL_ZERO);
            OP_DIV:
                rule_hit = (a.cls == CL_ZERO && b.cls == CL_ZERO) ||
                           (a.cls == CL_INF  && b.cls == CL_INF);
            OP_SQRT:
                rule_hit = a.sign && (a.cls == CL_FIN || a.cls == CL_INF);
            OP_CVT:
                rule_hit = (a.cls == CL_INF) || is_nan(a.cls) || cvt_over;
            OP_CEQ:
                rule_hit = 1'b0;
            OP_CORD:
                rule_hit = is_nan(a.cls) || is_nan(b.cls);
            default:
                rule_hit = 1'b0;
        endcase
    end

    assign inv = snan_hit || rule_hit;
    assign dz  = (op == OP_DIV) && (b.cls == CL_ZERO) && (a.cls == CL_FIN);

    always_comb begin
        verdict.invalid     = inv;
        verdict.div_zero    = dz;
        verdict.subst_valid = 1'b0;
        verdict.subst       = '0;
        if (inv && has_fp_dest(op)) begin
            verdict.subst_valid = 1'b1;
            verdict.subst       = QNAN_DEF;
        end else if (dz) begin
            verdict.subst_valid = 1'b1;
            verdict.subst       = signed_inf(a.sign ^ b.sign);
        end
    end
endmodule

// File: rtl/fp_exc_screen.sv
module fp_exc_screen
    import fpx_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OP_W-1:0] op,
    input  logic [FP_W-1:0] opa,
    input  logic [FP_W-1:0] opb,
    output logic            out_valid,
    output logic            invalid,
    output logic            div_zero,
    output logic            subst_valid,
    output logic [FP_W-1:0] subst
);
    localparam int N_OPND = 2;

    logic [FP_W-1:0] words [N_OPND];
    fpx_opnd_t       info  [N_OPND];
    fpx_verdict_t    verdict_c;
    fpx_verdict_t    verdict_q;
    logic            valid_q;

    assign words[0] = opa;
    assign words[1] = opb;

    for (genvar i = 0; i < N_OPND; i++) begin : g_cls
        fpx_classify u_cls (
            .word (words[i]),
            .info (info[i])
        );
    end

    fpx_rules #(.INT_W(INT_W)) u_rules (
        .op      (fpx_op_e'(op)),
        .a       (info[0]),
        .b       (info[1]),
        .verdict (verdict_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= '0;
        end else begin
            valid_q   <= in_valid;
            verdict_q <= in_valid ? verdict_c : '0;
        end
    end

    assign out_valid   = valid_q;
    assign invalid     = verdict_q.invalid;
    assign div_zero    = verdict_q.div_zero;
    assign subst_valid = verdict_q.subst_valid;
    assign subst       = verdict_q.subst;
endmodule

// File: rtl/fpx_exc_checker.sv
module fpx_exc_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [2:0]  op,
    input logic [31:0] opa,
    input logic [31:0] opb,
    input logic        out_valid,
    input logic        invalid,
    input logic        div_zero,
    input logic        subst_valid,
    input logic [31:0] subst
);
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!invalid && !div_zero && !subst_valid));

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(invalid && div_zero));

    p_dz_only_divide_r9: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> ($past(op) == 3'd3 && $past(opb[30:0]) == 31'd0));

    p_dz_signed_inf_r10: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> (subst_valid &&
                      subst == {$past(opa[31] ^ opb[31]), 8'hFF, 23'd0}));

    p_default_qnan_r10: assert property (@(posedge clk) disable iff (rst)
        (invalid && subst_valid) |-> (subst == 32'h7FC0_0000));

    p_snan_opa_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opa[30:22] == 9'b1_1111_1110 && opa[21:0] != 22'd0)
        |=> invalid);
endmodule

bind fp_exc_screen fpx_exc_checker u_chk (.*);

// File: tb/fp_exc_screen_tb.sv
module fp_exc_screen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid, invalid, div_zero, subst_valid;
    logic [31:0] subst;

    fp_exc_screen u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .out_valid(out_valid), .invalid(invalid),
        .div_zero(div_zero), .subst_valid(subst_valid), .subst(subst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        inv;
        logic        dz;
        logic        sv;
        logic [31:0] sub;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;

    localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
    localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
    localparam logic [31:0] ONE = 32'h3F80_0000, NONE = 32'hBF80_0000;
    localparam logic [31:0] TWO = 32'h4000_0000, QN = 32'h7FC0_0000;
    localparam logic [31:0] NQN = 32'hFFC0_0000, SN = 32'h7F80_0001;
    localparam logic [31:0] PSUB = 32'h0000_0001, NSUB = 32'h8000_0001;

    task automatic push(input logic [2:0] o, input logic [31:0] a,
                        input logic [31:0] b, input logic inv,
                        input logic dz, input logic sv,
                        input logic [31:0] sub, input string tag);
        exp_t e;
        @(negedge clk);
        op = o; opa = a; opb = b; in_valid = 1'b1;
        e.inv = inv; e.dz = dz; e.sv = sv; e.sub = sub;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares each verdict one cycle after its request
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R1: out_valid with no request, got 1 expected 0");
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (invalid !== e.inv || div_zero !== e.dz ||
                    subst_valid !== e.sv || subst !== e.sub) begin
                    n_fail++;
                    $display("FAIL %s: got inv=%b dz=%b sv=%b sub=%h expected inv=%b dz=%b sv=%b sub=%h",
                             t, invalid, div_zero, subst_valid, subst,
                             e.inv, e.dz, e.sv, e.sub);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;  // R11 reset state
        if (out_valid !== 1'b0 || invalid !== 1'b0 || div_zero !== 1'b0 ||
            subst_valid !== 1'b0 || subst !== 32'd0) begin
            n_fail++;
            $display("FAIL R11: got %b%b%b%b %h expected 0000 00000000",
                     out_valid, invalid, div_zero, subst_valid, subst);
        end
        rst = 1'b0;

        // R2 add/subtract of infinities
        push(3'd0, PINF, NINF, 1, 0, 1, QN, "R2");
        push(3'd0, PINF, PINF, 0, 0, 0, 0, "R2");
        push(3'd1, PINF, PINF, 1, 0, 1, QN, "R2");
        push(3'd1, PINF, NINF, 0, 0, 0, 0, "R2");
        // R3 multiply
        push(3'd2, PZ, NINF, 1, 0, 1, QN, "R3");
        push(3'd2, NINF, NZ, 1, 0, 1, QN, "R3");
        push(3'd2, ONE, PINF, 0, 0, 0, 0, "R3");
        // R4 divide invalid
        push(3'd4 - 3'd1, NZ, PZ, 1, 0, 1, QN, "R4");
        push(3'd3, PINF, NINF, 1, 0, 1, QN, "R4");
        // R9 R10 divide by zero
        push(3'd3, NONE, PZ, 0, 1, 1, NINF, "R9");
        push(3'd3, ONE, PZ, 0, 1, 1, PINF, "R10");
        push(3'd3, NSUB, NZ, 0, 1, 1, PINF, "R10");
        push(3'd3, PINF, PZ, 0, 0, 0, 0, "R9");
        push(3'd3, QN, PZ, 0, 0, 0, 0, "R9");
        push(3'd3, SN, PZ, 1, 0, 1, QN, "R9");
        // R5 square root
        push(3'd4, NONE, PZ, 1, 0, 1, QN, "R5");
        push(3'd4, NZ, PZ, 0, 0, 0, 0, "R5");
        push(3'd4, NINF, PZ, 1, 0, 1, QN, "R5");
        push(3'd4, NSUB, PZ, 1, 0, 1, QN, "R5");
        push(3'd4, NQN, PZ, 0, 0, 0, 0, "R5");
        push(3'd4, ONE, SN, 0, 0, 0, 0, "R7");
        // R6 convert
        push(3'd5, PINF, PZ, 1, 0, 0, 0, "R6");
        push(3'd5, QN, PZ, 1, 0, 0, 0, "R6");
        push(3'd5, 32'h4F00_0000, PZ, 1, 0, 0, 0, "R6");
        push(3'd5, 32'hCF00_0000, PZ, 0, 0, 0, 0, "R6");
        push(3'd5, 32'h4EFF_FFFF, PZ, 0, 0, 0, 0, "R6");
        push(3'd5, 32'hCF00_0001, PZ, 1, 0, 0, 0, "R6");
        push(3'd5, ONE, SN, 0, 0, 0, 0, "R7");
        // R7 signaling NaN
        push(3'd0, ONE, SN, 1, 0, 1, QN, "R7");
        push(3'd2, SN, ONE, 1, 0, 1, QN, "R7");
        push(3'd0, QN, ONE, 0, 0, 0, 0, "R7");
        // R8 compares
        push(3'd6, QN, ONE, 0, 0, 0, 0, "R8");
        push(3'd6, SN, ONE, 1, 0, 0, 0, "R8");
        push(3'd7, ONE, QN, 1, 0, 0, 0, "R8");
        push(3'd7, ONE, TWO, 0, 0, 0, 0, "R8");
        push(3'd0, PSUB, TWO, 0, 0, 0, 0, "R1");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        n_checks++;  // R1 idle cycles stay quiet
        if (out_valid !== 1'b0 || invalid !== 1'b0 || div_zero !== 1'b0 ||
            subst_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: idle got %b%b%b%b expected 0000",
                     out_valid, invalid, div_zero, subst_valid);
        end
        n_checks++;  // R1 every request answered
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1: got %0d unanswered requests expected 0",
                     exp_q.size());
        end
        finish_run();
    end
endmodule